// File: doc/BRIEF.md
# LCD Panel Timing Pulse Generator

This block turns the horizontal and vertical sync of a display controller into the control strobes that a panel's row and column drivers need. There are seven channels: two gate-start strobes, plus source start, source output enable, gate clock and two polarity signals. The gate-start channels count lines from VSYNC. The other five count pixel clocks from HSYNC. Each channel has a timing word that gives a start offset and a pulse width. It also has a control word that picks which generated pulse drives its pin, whether that pin is inverted, and a line-alternating polarity pattern.

Software writes the timing and control words over a simple 32-bit write bus into a shadow set. The shadow set reaches the active set only after a commit request. The commit itself waits for the next VSYNC leading edge, so the panel never sees a frame with mixed settings. Pixel data does not pass through this block.

Top module: `lcdPulseGen`

## Requirements
- R1: During and just after reset every strobe output is low. Counters and frame parity are zero, and each channel routes its own pulse (select code equal to its index) with width zero.
- R2: A timing word keeps its start offset in bits [31:16] and its width in bits [15:0]. On channels 2 to 6 the pixel counter is zero in the cycle after the clock edge that first samples HSYNC high. It then counts up by one per clock and saturates. The pulse is high while start <= count < start + width.
- R3: On channels 0 and 1 the line counter is zero after a VSYNC leading edge. Otherwise it rises by one on each HSYNC leading edge, and the pulse is high while start <= line < start + width.
- R4: A width of zero keeps a pulse inactive at every count. The pin then shows only its inversion and polarity pattern.
- R5: Control bit 4 inverts the channel's pin.
- R6: Control bits [2:0] choose the source for a pin. Codes 0 to 6 pick the pulse generated from channel 0 to 6's timing word, and code 7 passes the `deIn` input through.
- R7: Control bits [13:12] choose a polarity pattern that is XORed onto the pin: 0 none, 1 line bit 0, 2 line bit 1, 3 line bit 0 XOR line bit 1. Every pattern is further XORed with a frame parity bit that toggles on each VSYNC leading edge.
- R8: Writes land in shadow registers and do not change the pins. A write of 1 in bit 0 to address 15 arms a commit. The active set takes the shadow values on the next VSYNC leading edge, and the change shows from the following cycle.
- R9: A write to address 15 with bit 0 clear arms nothing and has no effect on the pins.
- R10: Channel i's timing word sits at address i and its control word at address 8 + i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hsync | input | 1 | Horizontal sync, active high |
| vsync | input | 1 | Vertical sync, active high |
| deIn | input | 1 | Data enable passed through to any pin that selects code 7 |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register word address |
| regWrData | input | 32 | Register write data |
| strobeOut | output | 7 | Panel control strobes, bit i belongs to channel i |

## Verification
The bench runs a small frame of six lines of 24 clocks. It compares all seven pins in every cycle against a model built from the requirements. Offsets, widths and pulses that run past the line end show up first as pixel-count pulses and then as line-count pulses, which tells the two counter references apart. A zero width, inversion, a remapped source and `deIn` routing each alter a single pin while the others stay fixed. Runs across several frames with each polarity pattern separate the line-bit choices and expose the per-frame phase flip. Writes made without a commit, or with bit 0 clear, and a commit armed in the middle of a frame show that the pins change only at the next VSYNC.

// File: rtl/lcdPulsePkg.sv
package lcdPulsePkg;
  localparam int NCH       = 7;       // output channels
  localparam int NUM_VCH   = 2;       // channels 0..NUM_VCH-1 count lines
  localparam int NSRC      = NCH + 1; // pulse sources incl. data enable
  localparam int TIM_BASE  = 0;
  localparam int CTL_BASE  = 8;
  localparam int LATCH_ADR = 15;

  typedef struct packed {
    logic [1:0] mode;
    logic       inv;
    logic [2:0] sel;
  } chanCtl_t;

  typedef struct packed {
    logic commit;
    logic frameOdd;
  } tpgStrb_t;
endpackage

// File: rtl/lcdPulseCtrl.sv
module lcdPulseCtrl
  import lcdPulsePkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hsync,
  input  logic             vsync,
  input  logic             latchWr,
  output tpgStrb_t         strb,
  output logic [CNT_W-1:0] hCnt,
  output logic [CNT_W-1:0] vCnt
);
  logic hsPrev, vsPrev, pending, frameOdd;
  logic hEdge, vEdge, commit;

  assign hEdge  = hsync & ~hsPrev;
  assign vEdge  = vsync & ~vsPrev;
  assign commit = vEdge & pending;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hsPrev   <= 1'b0;
      vsPrev   <= 1'b0;
      pending  <= 1'b0;
      frameOdd <= 1'b0;
      hCnt     <= '0;
      vCnt     <= '0;
    end else begin
      hsPrev  <= hsync;
      vsPrev  <= vsync;
      pending <= latchWr | (pending & ~commit);
      if (vEdge) frameOdd <= ~frameOdd;
      if (hEdge) hCnt <= '0;
      else if (hCnt != '1) hCnt <= hCnt + 1'b1;
      if (vEdge) vCnt <= '0;
      else if (hEdge && vCnt != '1) vCnt <= vCnt + 1'b1;
    end
  end

  assign strb.commit   = commit;
  assign strb.frameOdd = frameOdd;
endmodule

// File: rtl/lcdPulseData.sv
module lcdPulseData
  import lcdPulsePkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  input  tpgStrb_t          strb,
  input  logic [CNT_W-1:0]  hCnt,
  input  logic [CNT_W-1:0]  vCnt,
  input  logic              deIn,
  output logic [NCH-1:0]    strobeOut
);
  logic [NCH-1:0][31:0] shTim, acTim;
  chanCtl_t [NCH-1:0]   shCtl, acCtl;
  logic [NSRC-1:0]      srcVec;

  // shadow and active register sets
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NCH; i++) begin
        shTim[i] <= '0;
        acTim[i] <= '0;
        shCtl[i] <= '{mode: 2'd0, inv: 1'b0, sel: 3'(i)};
        acCtl[i] <= '{mode: 2'd0, inv: 1'b0, sel: 3'(i)};
      end
    end else begin
      if (strb.commit) begin
        acTim <= shTim;
        acCtl <= shCtl;
      end
      if (regWrEn) begin
        for (int i = 0; i < NCH; i++) begin
          if (regAddr == ADDR_W'(TIM_BASE + i)) shTim[i] <= regWrData;
          if (regAddr == ADDR_W'(CTL_BASE + i))
            shCtl[i] <= '{mode: regWrData[13:12], inv: regWrData[4],
                          sel: regWrData[2:0]};
        end
      end
    end
  end

  // pulse generation, one window compare per channel
  for (genvar g = 0; g < NCH; g++) begin : gSrc
    logic [16:0] cntX, stX, endX;
    if (g < NUM_VCH) begin : gLine
      assign cntX = 17'(vCnt);
    end else begin : gPix
      assign cntX = 17'(hCnt);
    end
    assign stX  = {1'b0, acTim[g][31:16]};
    assign endX = stX + {1'b0, acTim[g][15:0]};
    assign srcVec[g] = (cntX >= stX) && (cntX < endX);
  end
  assign srcVec[NSRC-1] = deIn;

  // output routing, polarity pattern and inversion
  for (genvar g = 0; g < NCH; g++) begin : gOut
    chanCtl_t c;
    logic     ph;
    assign c = acCtl[g];
    always_comb begin
      case (c.mode)
        2'd1:    ph = vCnt[0] ^ strb.frameOdd;
        2'd2:    ph = vCnt[1] ^ strb.frameOdd;
        2'd3:    ph = vCnt[0] ^ vCnt[1] ^ strb.frameOdd;
        default: ph = 1'b0;
      endcase
    end
    assign strobeOut[g] = srcVec[c.sel] ^ ph ^ c.inv;
  end
endmodule

// File: rtl/lcdPulseGen.sv
module lcdPulseGen
  import lcdPulsePkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hsync,
  input  logic              vsync,
  input  logic              deIn,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [NCH-1:0]    strobeOut
);
  tpgStrb_t         strb;
  logic [CNT_W-1:0] hCnt, vCnt;
  logic             latchWr;

  assign latchWr = regWrEn && (regAddr == ADDR_W'(LATCH_ADR)) && regWrData[0];

  lcdPulseCtrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .hsync(hsync), .vsync(vsync),
    .latchWr(latchWr), .strb(strb), .hCnt(hCnt), .vCnt(vCnt)
  );

  lcdPulseData #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) uData (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .strb(strb), .hCnt(hCnt), .vCnt(vCnt),
    .deIn(deIn), .strobeOut(strobeOut)
  );
endmodule

// File: rtl/lcdPulseChk.sv
module lcdPulseChk
  import lcdPulsePkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 hsync,
  input logic                 vsync,
  input logic [NCH-1:0]       strobeOut,
  input logic [CNT_W-1:0]     hCnt,
  input logic [CNT_W-1:0]     vCnt,
  input logic                 frameOdd,
  input logic                 commit,
  input logic [NCH-1:0][31:0] acTim
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $rose(rstN) |-> strobeOut == '0);

  // R2
  pix_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hsync) |=> hCnt == '0);

  // R3
  line_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(vsync) |=> vCnt == '0);

  // R7
  frame_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(vsync) |=> frameOdd != $past(frameOdd));

  // R8
  active_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !commit |=> $stable(acTim));
endmodule

bind lcdPulseGen lcdPulseChk #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .hsync(hsync), .vsync(vsync),
  .strobeOut(strobeOut), .hCnt(hCnt), .vCnt(vCnt),
  .frameOdd(strb.frameOdd), .commit(strb.commit), .acTim(uData.acTim)
);

// File: tb/tb_lcdPulseGen.sv
`timescale 1ns/1ps
module tb_lcdPulseGen;
  localparam int NCH = 7;
  localparam int HT  = 24;
  localparam int NL  = 6;
  localparam int FR  = HT * NL;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           hsync = 1'b0, vsync = 1'b0, deIn = 1'b0;
  logic           regWrEn = 1'b0;
  logic [3:0]     regAddr = '0;
  logic [31:0]    regWrData = '0;
  logic [NCH-1:0] strobeOut;

  always #2.5 clk = ~clk;

  lcdPulseGen dut (
    .clk(clk), .rstN(rstN), .hsync(hsync), .vsync(vsync), .deIn(deIn),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .strobeOut(strobeOut)
  );

  int checks = 0, failures = 0;
  bit done = 0;

  // stimulus variables and reference model state
  logic        wEn = 0;
  logic [3:0]  wAddr = 0;
  logic [31:0] wData = 0;
  int          pos = 0;
  logic [31:0] mShT[NCH], mAcT[NCH];
  int          mShSel[NCH], mAcSel[NCH], mShMode[NCH], mAcMode[NCH];
  logic        mShInv[NCH], mAcInv[NCH];
  logic        mHsP = 0, mVsP = 0, mPend = 0, mFrame = 0, mDe = 0;
  int          mH = 0, mV = 0;

  function automatic logic [NCH-1:0] expVec();
    logic [NCH-1:0] r;
    for (int k = 0; k < NCH; k++) begin
      int  s, st, w, c;
      logic src, ph;
      s = mAcSel[k];
      if (s == 7) src = mDe;
      else begin
        st  = int'(mAcT[s][31:16]);
        w   = int'(mAcT[s][15:0]);
        c   = (s < 2) ? mV : mH;
        src = (c >= st) && (c < st + w);
      end
      case (mAcMode[k])
        1:       ph = mV[0] ^ mFrame;
        2:       ph = mV[1] ^ mFrame;
        3:       ph = mV[0] ^ mV[1] ^ mFrame;
        default: ph = 1'b0;
      endcase
      r[k] = src ^ ph ^ mAcInv[k];
    end
    return r;
  endfunction

  task automatic step(input string tag);
    logic hs, vs, de, hE, vE, com;
    int   line, col;
    @(negedge clk);
    if (!done) begin
      checks++;
      if (strobeOut !== expVec()) begin
        failures++;
        $display("FAIL %s pos=%0d actual=%b expected=%b", tag, pos, strobeOut, expVec());
      end
    end
    line = pos / HT;
    col  = pos % HT;
    hs = (col < 2);
    vs = (line == 0) && (col < 2);
    de = (col >= 4) && (col < 20);
    hsync = hs; vsync = vs; deIn = de;
    regWrEn = wEn; regAddr = wAddr; regWrData = wData;
    // model of the coming clock edge
    hE  = hs & ~mHsP;
    vE  = vs & ~mVsP;
    com = vE & mPend;
    if (com) begin
      for (int k = 0; k < NCH; k++) begin
        mAcT[k] = mShT[k]; mAcSel[k] = mShSel[k];
        mAcMode[k] = mShMode[k]; mAcInv[k] = mShInv[k];
      end
    end
    mPend = (wEn && wAddr == 4'd15 && wData[0]) || (mPend && !com);
    if (wEn) begin
      for (int k = 0; k < NCH; k++) begin
        if (wAddr == 4'(k)) mShT[k] = wData;
        if (wAddr == 4'(8 + k)) begin
          mShSel[k]  = int'(wData[2:0]);
          mShInv[k]  = wData[4];
          mShMode[k] = int'(wData[13:12]);
        end
      end
    end
    if (vE) mFrame = ~mFrame;
    if (hE) mH = 0; else if (mH < 65535) mH++;
    if (vE) mV = 0; else if (hE && mV < 65535) mV++;
    mHsP = hs; mVsP = vs; mDe = de;
    pos = (pos + 1) % FR;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input string tag);
    wEn = 1; wAddr = a; wData = d;
    step(tag);
    wEn = 0;
  endtask

  task automatic frames(input int n, input string tag);
    repeat (n * FR) step(tag);
  endtask

  function automatic logic [31:0] tim(input int st, input int w);
    return {16'(st), 16'(w)};
  endfunction

  initial begin
    for (int k = 0; k < NCH; k++) begin
      mShT[k] = 0; mAcT[k] = 0; mShSel[k] = k; mAcSel[k] = k;
      mShMode[k] = 0; mAcMode[k] = 0; mShInv[k] = 0; mAcInv[k] = 0;
    end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R1: quiet outputs after reset
    repeat (20) step("R1");
    // R8: shadow writes without commit leave pins untouched (R10 map)
    wr(4'd0, tim(1, 2), "R8");
    wr(4'd1, tim(4, 1), "R8");
    wr(4'd2, tim(5, 3), "R8");
    wr(4'd3, tim(10, 1), "R8");
    wr(4'd4, tim(0, 30), "R8");
    wr(4'd5, tim(7, 4), "R8");
    wr(4'd6, tim(20, 6), "R8");
    frames(1, "R8");
    // R9: latch write with bit 0 clear
    wr(4'd15, 32'hFFFF_FFFE, "R9");
    frames(1, "R9");
    // R8: commit armed mid-frame, applied at next VSYNC
    repeat (50) step("R8");
    wr(4'd15, 32'd1, "R8");
    frames(1, "R2");
    frames(1, "R3");
    // R10: control word of channel 1 at address 9
    wr(4'd9, 32'h0000_0011, "R10");
    wr(4'd15, 32'd1, "R10");
    frames(1, "R10");
    // R4 / R5: zero width and inversion
    wr(4'd2, tim(5, 0), "R4");
    wr(4'd13, 32'h0000_0015, "R5");
    wr(4'd0, tim(0, 0), "R4");
    wr(4'd15, 32'd1, "R4");
    frames(1, "R4");
    frames(1, "R5");
    // R6: source remap and data enable pass-through
    wr(4'd0, tim(1, 2), "R6");
    wr(4'd11, 32'd0, "R6");
    wr(4'd12, 32'd7, "R6");
    wr(4'd14, 32'd2, "R6");
    wr(4'd8, 32'd1, "R6");
    wr(4'd15, 32'd1, "R6");
    frames(2, "R6");
    // R7: polarity patterns over several frames
    wr(4'd13, 32'h0000_1005, "R7");
    wr(4'd14, 32'h0000_2006, "R7");
    wr(4'd8, 32'h0000_3000, "R7");
    wr(4'd12, 32'h0000_1014, "R7");
    wr(4'd15, 32'd1, "R7");
    frames(3, "R7");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule